// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a programmable interval timer. Its count rate is split across two stages. A 6-bit prescaler divides the enabled count ticks by a value from 1 to 64. Each time the prescaler wraps, an 8-bit main counter steps down once, and that counter covers 1 to 256 steps. When both stages reach the end of their count on the same tick, the timer raises a one-cycle request. That request also serves as a terminal-count pulse for chaining timers, and it flips a timer-output level.

Software reaches the timer through a small write port. Four selectable registers hold the prescaler start value, the counter start value, a command code and the run mode. The commands halt the timer, resume it from the held state, or reload both stages from their start values and run. The mode selects a single pass, which stops with the counter at zero, or continuous operation, which reloads the counter and carries on. The counter value is always visible on an output, and reading it has no side effects. The count source is an enable input that the surrounding logic pulses at the wanted rate.

Top module: `pdt_timer`

## Requirements
- R1: After reset, cur_count, irq, tc_pulse and tout are 0 and the timer is halted.
- R2: wr_addr 0 holds the prescaler start value in wr_data[5:0]. The value 0 means 64. The counter steps down once for every that many count ticks.
- R3: wr_addr 1 holds the counter start value, where 0 means 256. irq and tc_pulse are high for exactly one cycle, in the cycle after the tick on which the prescaler and the counter both reach the end of their count.
- R4: wr_addr 3 bit 0 clear selects single pass. At expiry the counter is left at 0 and the timer halts, with no further requests.
- R5: wr_addr 3 bit 0 set selects continuous mode. At expiry the counter reloads its start value, so requests repeat every prescale times count ticks.
- R6: Writing command code 0 to wr_addr 2, in wr_data[1:0], halts both stages with their values held. Code 1 resumes counting from the held values.
- R7: Writing command code 2 to wr_addr 2 loads both stages from their start values and runs. The next cycle, cur_count equals the counter start value.
- R8: Writing command code 3 to wr_addr 2 has no effect.
- R9: A write to either start value leaves the current count unchanged. The new value is used only at the next reload or restart.
- R10: A count tick occurs only in a cycle where cnt_en is high, the timer is running, and no command is being written.
- R11: tout toggles once on each expiry and is otherwise steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 prescale, 1 count, 2 command, 3 mode |
| wr_data | input | 8 | Write data |
| cnt_en | input | 1 | Count-source enable |
| cur_count | output | 8 | Current main counter value |
| irq | output | 1 | Expiry interrupt request, one cycle |
| tc_pulse | output | 1 | Terminal-count pulse for chaining |
| tout | output | 1 | Timer output, toggles on each expiry |

## Verification
The bench goes after the encoded maximum counts, a full 64 x 256 single pass. A design that decoded 0 literally would expire at once or never stop. It also checks divide-by-one in both stages. There, a request is due on every enabled cycle, and a timer that forced a gap between requests would drop half of them. The bench also exercises start-value writes during a run, halt followed by resume with a partly used prescaler, and the ignored command code. A design that reloaded on the write, cleared the prescaler on resume, or treated code 3 as a restart would move the count away from the bench's model. Random register traffic mixed with a gated count source checks, every cycle, that a command cycle and a disabled cycle never count.

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_PRE_INIT = 2'd0,
      SEL_CNT_INIT = 2'd1,
      SEL_CMD      = 2'd2,
      SEL_MODE     = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_HALT   = 2'd0,
      OP_RESUME = 2'd1,
      OP_RELOAD = 2'd2,
      OP_NONE   = 2'd3
   } op_code_e;

   typedef struct packed {
      logic halt;
      logic resume;
      logic reload;
   } op_strobe_t;
endpackage

// File: rtl/pdt_regs.sv
`timescale 1ns/1ps
module pdt_regs
   import pdt_pkg::*;
#(
   parameter int PRE_W  = 6,
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PRE_W-1:0]  pre_init,
   output logic [CNT_W-1:0]  cnt_init,
   output logic              cont_mode,
   output logic              op_wr,
   output op_strobe_t        op
);
   logic     sel_pre, sel_cnt, sel_mode;
   op_code_e code;

   assign sel_pre  = wr_en && (reg_sel_e'(wr_addr) == SEL_PRE_INIT);
   assign sel_cnt  = wr_en && (reg_sel_e'(wr_addr) == SEL_CNT_INIT);
   assign sel_mode = wr_en && (reg_sel_e'(wr_addr) == SEL_MODE);
   assign op_wr    = wr_en && (reg_sel_e'(wr_addr) == SEL_CMD);
   assign code     = op_code_e'(wr_data[1:0]);

   always_comb begin
      op        = '0;
      op.halt   = op_wr && (code == OP_HALT);
      op.resume = op_wr && (code == OP_RESUME);
      op.reload = op_wr && (code == OP_RELOAD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_init  <= '0;
         cnt_init  <= '0;
         cont_mode <= 1'b0;
      end else begin
         if (sel_pre)  pre_init  <= wr_data[PRE_W-1:0];
         if (sel_cnt)  cnt_init  <= wr_data[CNT_W-1:0];
         if (sel_mode) cont_mode <= wr_data[0];
      end
   end
endmodule

// File: rtl/pdt_stage.sv
`timescale 1ns/1ps
module pdt_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] wrap_val,
   output logic [W-1:0] val,
   output logic         last
);
   localparam logic [W-1:0] ONE = W'(1);

   assign last = (val == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)     val <= '0;
      else if (load)  val <= load_val;
      else if (step)  val <= last ? wrap_val : val - ONE;
   end
endmodule

// File: rtl/pdt_ctrl.sv
`timescale 1ns/1ps
module pdt_ctrl
   import pdt_pkg::*;
#(
   parameter bit TOUT_TOGGLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  op_strobe_t op,
   input  logic       op_wr,
   input  logic       cnt_en,
   input  logic       cont_mode,
   input  logic       pre_last,
   input  logic       cnt_last,
   output logic       tick,
   output logic       cnt_step,
   output logic       tc_q,
   output logic       tout
);
   logic run_q;
   logic expire;

   assign tick     = run_q && cnt_en && !op_wr;
   assign cnt_step = tick && pre_last;
   assign expire   = cnt_step && cnt_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         tc_q  <= 1'b0;
      end else begin
         tc_q <= expire;
         if (op.halt)                     run_q <= 1'b0;
         else if (op.resume || op.reload) run_q <= 1'b1;
         else if (expire && !cont_mode)   run_q <= 1'b0;
      end
   end

   generate
      if (TOUT_TOGGLE) begin : g_tout_toggle
         logic tout_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      tout_q <= 1'b0;
            else if (expire) tout_q <= !tout_q;
         end
         assign tout = tout_q;
      end else begin : g_tout_pulse
         assign tout = tc_q;
      end
   endgenerate
endmodule

// File: rtl/pdt_timer.sv
`timescale 1ns/1ps
module pdt_timer
   import pdt_pkg::*;
#(
   parameter int PRE_W       = 6,
   parameter int CNT_W       = 8,
   parameter int DATA_W      = 8,
   parameter bit TOUT_TOGGLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cnt_en,
   output logic [CNT_W-1:0]  cur_count,
   output logic              irq,
   output logic              tc_pulse,
   output logic              tout
);
   generate
      if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre_w
         $error("pdt_timer: PRE_W must be within 1..DATA_W");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("pdt_timer: CNT_W must be within 2..DATA_W");
      end
   endgenerate

   logic [PRE_W-1:0] pre_init, pre_val;
   logic [CNT_W-1:0] cnt_init, cnt_wrap;
   logic             cont_mode, op_wr, pre_last, cnt_last;
   logic             tick, cnt_step, tc_q;
   op_strobe_t       op;

   pdt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pre_init(pre_init), .cnt_init(cnt_init),
      .cont_mode(cont_mode), .op_wr(op_wr), .op(op)
   );

   pdt_stage #(.W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .load(op.reload), .load_val(pre_init),
      .step(tick), .wrap_val(pre_init), .val(pre_val), .last(pre_last)
   );

   assign cnt_wrap = cont_mode ? cnt_init : '0;

   pdt_stage #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(op.reload), .load_val(cnt_init),
      .step(cnt_step), .wrap_val(cnt_wrap), .val(cur_count), .last(cnt_last)
   );

   pdt_ctrl #(.TOUT_TOGGLE(TOUT_TOGGLE)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .op(op), .op_wr(op_wr), .cnt_en(cnt_en),
      .cont_mode(cont_mode), .pre_last(pre_last), .cnt_last(cnt_last),
      .tick(tick), .cnt_step(cnt_step), .tc_q(tc_q), .tout(tout)
   );

   assign irq      = tc_q;
   assign tc_pulse = tc_q;
endmodule

// File: rtl/pdt_timer_chk.sv
`timescale 1ns/1ps
module pdt_timer_chk #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              cnt_en,
   input logic [CNT_W-1:0]  cur_count,
   input logic              irq,
   input logic              tout,
   input logic              cont_mode,
   input logic [CNT_W-1:0]  cnt_init
);
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !wr_en) |=> $stable(cur_count));

   p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && wr_data[1:0] == 2'd0) |=> ($stable(cur_count) && !irq));

   p_reload_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && wr_data[1:0] == 2'd2) |=> (cur_count == $past(cnt_init)));

   p_single_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(cont_mode)) |-> (cur_count == '0));

   p_tout_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (tout != $past(tout)));

   p_tout_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> $stable(tout));
endmodule

bind pdt_timer pdt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .cnt_en(cnt_en), .cur_count(cur_count), .irq(irq),
   .tout(tout), .cont_mode(cont_mode), .cnt_init(cnt_init)
);

// File: tb/pdt_timer_tb_top.sv
`timescale 1ns/1ps
module pdt_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       cnt_en = 1'b0;
   logic [7:0] cur_count;
   logic       irq, tc_pulse, tout;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   pdt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_en(cnt_en), .cur_count(cur_count),
      .irq(irq), .tc_pulse(tc_pulse), .tout(tout)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model, built from the requirements
   logic [5:0] m_pre, m_pinit;
   logic [7:0] m_cnt, m_cinit;
   logic       m_run, m_mode, m_irq, m_tout;

   function automatic logic [7:0] dec8(input logic [7:0] v);
      return v - 8'd1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = '0; m_pinit = '0; m_cnt = '0; m_cinit = '0;
         m_run = 0; m_mode = 0; m_irq = 0; m_tout = 0;
      end else begin
         logic cmdw;
         cmdw  = wr_en && wr_addr == 2'd2;
         m_irq = 1'b0;
         if (cmdw) begin
            case (wr_data[1:0])
               2'd0: m_run = 1'b0;
               2'd1: m_run = 1'b1;
               2'd2: begin m_pre = m_pinit; m_cnt = m_cinit; m_run = 1'b1; end
               default: ;
            endcase
         end else if (m_run && cnt_en) begin
            if (m_pre == 6'd1) begin
               m_pre = m_pinit;
               if (m_cnt == 8'd1) begin
                  m_irq  = 1'b1;
                  m_tout = !m_tout;
                  m_cnt  = m_mode ? m_cinit : 8'd0;
                  if (!m_mode) m_run = 1'b0;
               end else m_cnt = dec8(m_cnt);
            end else m_pre = m_pre - 6'd1;
         end
         if (wr_en && wr_addr == 2'd0) m_pinit = wr_data[5:0];
         if (wr_en && wr_addr == 2'd1) m_cinit = wr_data;
         if (wr_en && wr_addr == 2'd3) m_mode  = wr_data[0];
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2", "cur_count vs model", cur_count, m_cnt);
         chk("R3", "irq vs model", irq, m_irq);
         chk("R3", "tc_pulse vs model", tc_pulse, m_irq);
         chk("R11", "tout vs model", tout, m_tout);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] after_one_step(input logic [7:0] held, input logic [7:0] init);
      return (held > 8'd1) ? held - 8'd1 : init;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      logic [7:0] c0;
      bit seen;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R1", "reset cur_count", cur_count, 0);
      chk("R1", "reset irq", irq, 0);
      chk("R1", "reset tc_pulse", tc_pulse, 0);
      chk("R1", "reset tout", tout, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      cnt_en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1", "halted after reset", cur_count, 0);
      cnt_en = 1'b0;

      // divide-by-one in both stages, continuous
      wr(2'd0, 8'd1); wr(2'd1, 8'd1); wr(2'd3, 8'd1); wr(2'd2, 8'd2);
      repeat (5) @(negedge clk);
      chk("R10", "no count with cnt_en low", cur_count, 1);
      chk("R10", "no irq with cnt_en low", irq, 0);
      cnt_en = 1'b1;
      n = 0;
      repeat (8) begin @(negedge clk); if (irq) n++; end
      chk("R3", "irq every cycle at 1x1", n, 8);

      // period 3 x 4
      wr(2'd0, 8'd3); wr(2'd1, 8'd4); wr(2'd2, 8'd2);
      while (!irq) @(negedge clk);
      chk("R5", "reload value at expiry", cur_count, 4);
      n = 0;
      do begin @(negedge clk); n++; end while (!irq);
      chk("R2", "period 3x4 ticks", n, 12);

      // start-value write during a run
      cnt_en = 1'b0;
      @(negedge clk);
      c0 = cur_count;
      wr(2'd1, 8'd9);
      chk("R9", "count unchanged by start write", cur_count, c0);
      wr(2'd2, 8'd2);
      chk("R7", "restart loads start value", cur_count, 9);
      cnt_en = 1'b1;
      repeat (7) @(negedge clk);

      // halt and resume
      wr(2'd2, 8'd0);
      c0 = cur_count; seen = 0;
      repeat (20) begin @(negedge clk); if (irq) seen = 1; end
      chk("R6", "halt holds count", cur_count, c0);
      chk("R6", "no irq while halted", seen, 0);
      wr(2'd2, 8'd1);
      repeat (3) @(negedge clk);
      chk("R6", "resume from held state", cur_count, after_one_step(c0, 8'd9));

      // ignored code
      wr(2'd2, 8'd0);
      c0 = cur_count;
      wr(2'd2, 8'd3);
      repeat (10) @(negedge clk);
      chk("R8", "code 3 does not start", cur_count, c0);

      // full single pass at maximum encoded counts
      wr(2'd3, 8'd0); wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd2);
      chk("R3", "zero start value loads as 0", cur_count, 0);
      n = 0;
      while (!irq) begin @(negedge clk); n++; end
      chk("R3", "64x256 single pass length", n, 16384);
      chk("R4", "single pass ends at zero", cur_count, 0);
      seen = 0;
      repeat (300) begin @(negedge clk); if (irq) seen = 1; end
      chk("R4", "no request after single pass", seen, 0);
      chk("R4", "stays at zero", cur_count, 0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         cnt_en = ($urandom_range(0, 9) < 7);
         r = $urandom_range(0, 99);
         if (r < 4) wr(2'd2, 8'($urandom_range(0, 3)));
         else if (r < 7) wr(2'($urandom_range(0, 1)), 8'($urandom_range(0, 5)));
         else if (r < 8) wr(2'd3, 8'($urandom_range(0, 1)));
         else @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule